// File: doc/BRIEF.md
# Coherent Underflow-Recovering Sample Buffer

This block is a transmit sample buffer that sits between a bursty write side and a converter that reads at a fixed rate. The write side offers samples with a valid/ready handshake. The read side takes one sample in every cycle in which its consume enable is high, and it is never held off. Storage is a circular memory of 2^AW entries. Consumption begins only after a start pulse, so samples can be loaded ahead of the start time.

If the converter asks for a sample while storage is empty, the block outputs a zero-valued sample and adds one to a deficit counter. While that counter is nonzero, each sample accepted on the write side is discarded and the counter goes down by one. Late data is therefore dropped in exactly the amount needed to keep the output stream aligned with its original timeline. Normal storing resumes once the deficit reaches zero.

For an upstream rate loop the block reports the fill level, the signed distance from a programmable nominal level (85 percent of capacity after reset), a sticky underflow flag and a saturating total of inserted zeros.

Top module: `coherent_tx_fifo`

## Requirements
- R1: Before the start pulse has been registered, `consume_en` has no effect: `out_data`, `out_zero`, `zero_total` and the stored contents stay unchanged, and `streaming` reads 0. A `start` pulse in cycle k makes `streaming` high from cycle k+1 on.
- R2: In a streaming cycle with `consume_en` high and a nonempty buffer, the oldest stored sample appears on `out_data` after the next clock edge, with `out_zero` low. Samples come out in write order.
- R3: In a streaming cycle with `consume_en` high and an empty buffer, `out_data` becomes 0 and `out_zero` becomes 1 after the edge, and `deficit` rises by one.
- R4: While `deficit` is nonzero, `in_ready` is high and every accepted input sample is discarded. Each such sample lowers `deficit` by one and leaves the fill level unchanged.
- R5: With `deficit` at zero, an accepted sample is stored and raises the fill level by one. The first sample accepted after the deficit reaches zero is the first one stored.
- R6: `in_ready` is low only when the buffer holds 2^AW samples and `deficit` is zero. A write offered while `in_ready` is low is ignored.
- R7: A write and a consume in the same cycle, with the buffer empty and `deficit` zero, produce a zero output and raise `deficit` by one, and the written sample is stored, giving a fill level of 1.
- R8: `fill_level` equals the number of stored samples. `level_err` equals `fill_level` minus the nominal level as a two's-complement value. The nominal level resets to floor(2^AW × NOM_PCT / 100) and is loaded from `nominal_in` in any cycle with `nominal_we` high.
- R9: `underflow_flag` is set by every zero insertion and stays set until a cycle in which `underflow_clr` is high and no zero is inserted. If both happen in the same cycle, the set wins.
- R10: `zero_total` counts inserted zeros and saturates at 2^ZW − 1.
- R11: `deficit` saturates at 2^DEFW − 1. At that limit, further zero insertions leave it unchanged, and a drop in the same cycle still lowers it by one.
- R12: A synchronous active-high `rst` empties the buffer and clears `deficit`, `zero_total`, `underflow_flag`, `out_data`, `out_zero` and `streaming`. `in_ready` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins constant-rate consumption |
| consume_en | input | 1 | Converter takes one sample this cycle |
| in_valid | input | 1 | Write side offers a sample |
| in_ready | output | 1 | Sample will be accepted |
| in_data | input | DW | Offered sample |
| out_data | output | DW | Sample presented to the converter |
| out_zero | output | 1 | Last consumed sample was an inserted zero |
| streaming | output | 1 | Consumption has been started |
| fill_level | output | AW+1 | Number of stored samples |
| nominal_we | input | 1 | Load the nominal level |
| nominal_in | input | AW+1 | New nominal level |
| level_err | output | AW+2 | Signed fill minus nominal |
| deficit | output | DEFW | Samples still to be discarded |
| underflow_flag | output | 1 | Sticky underflow status |
| underflow_clr | input | 1 | Clears the sticky flag |
| zero_total | output | ZW | Saturating count of inserted zeros |

## Verification
The bench builds the block with AW=3 (eight entries), DW=8, DEFW=3 and ZW=4. The shallow memory makes full, wrap-around of the pointer top bit and the ready drop frequent events. A three-bit deficit lets a directed underflow of nine zeros reach the deficit limit (R11). A four-bit total lets the random phase reach the zero-count saturation (R10). With eight entries the default nominal level is 6, so `level_err` swings through both signs.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

   typedef enum logic [1:0] {
      OUT_HOLD = 2'd0,
      OUT_DATA = 2'd1,
      OUT_ZERO = 2'd2
   } ctf_out_e;

   function automatic int nominal_of(input int depth, input int pct);
      return (depth * pct) / 100;
   endfunction

endpackage

// File: rtl/ctf_store.sv
module ctf_store #(
   parameter int DW = 16,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/ctf_ptrs.sv
module ctf_ptrs #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   fill,
   output logic          full,
   output logic          empty
);
   logic [AW:0] wr_q, rd_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end

   assign waddr = wr_q[AW-1:0];
   assign raddr = rd_q[AW-1:0];
   assign fill  = wr_q - rd_q;
   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
endmodule

// File: rtl/ctf_deficit.sv
module ctf_deficit #(
   parameter int DEFW = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            inc,
   input  logic            dec,
   output logic [DEFW-1:0] cnt,
   output logic            nz
);
   localparam logic [DEFW-1:0] CMAX = '1;

   logic inc_eff;
   assign inc_eff = inc && (cnt != CMAX);

   always_ff @(posedge clk) begin
      if (rst)                  cnt <= '0;
      else if (inc_eff && !dec) cnt <= cnt + 1'b1;
      else if (dec && !inc_eff) cnt <= cnt - 1'b1;
   end

   assign nz = (cnt != '0);
endmodule

// File: rtl/ctf_satcnt.sv
module ctf_satcnt #(
   parameter int W   = 32,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   logic [W-1:0] nxt;

   generate
      if (SAT) begin : g_sat
         assign nxt = (cnt == '1) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (inc) cnt <= nxt;
   end
endmodule

// File: rtl/coherent_tx_fifo.sv
module coherent_tx_fifo #(
   parameter int DW        = 16,
   parameter int AW        = 6,
   parameter int DEFW      = 16,
   parameter int ZW        = 32,
   parameter int NOM_PCT   = 85,
   parameter bit TOTAL_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              consume_en,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DW-1:0]     in_data,
   output logic [DW-1:0]     out_data,
   output logic              out_zero,
   output logic              streaming,
   output logic [AW:0]       fill_level,
   input  logic              nominal_we,
   input  logic [AW:0]       nominal_in,
   output logic [AW+1:0]     level_err,
   output logic [DEFW-1:0]   deficit,
   output logic              underflow_flag,
   input  logic              underflow_clr,
   output logic [ZW-1:0]     zero_total
);
   import ctf_pkg::*;

   localparam int DEPTH   = 1 << AW;
   localparam int NOM_DEF = nominal_of(DEPTH, NOM_PCT);

   generate
      if (DW < 1) begin : g_bad_dw
         $error("coherent_tx_fifo: DW must be at least 1");
      end
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("coherent_tx_fifo: AW must lie in 1..12");
      end
      if (DEFW < 1 || DEFW > 32) begin : g_bad_defw
         $error("coherent_tx_fifo: DEFW must lie in 1..32");
      end
      if (ZW < 1 || ZW > 64) begin : g_bad_zw
         $error("coherent_tx_fifo: ZW must lie in 1..64");
      end
      if (NOM_PCT < 0 || NOM_PCT > 100) begin : g_bad_pct
         $error("coherent_tx_fifo: NOM_PCT must lie in 0..100");
      end
   endgenerate

   logic          running_q;
   logic [DW-1:0] out_q;
   logic          zero_q;
   logic          flag_q;
   logic [AW:0]   nominal_q;

   logic          consume, empty, full, def_nz;
   logic          accept, drop, store;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] rdata;
   ctf_out_e      outcome;

   assign consume  = running_q && consume_en;
   assign in_ready = def_nz || !full;
   assign accept   = in_valid && in_ready;
   assign drop     = accept && def_nz;
   assign store    = accept && !def_nz;

   always_comb begin
      if (!consume)   outcome = OUT_HOLD;
      else if (empty) outcome = OUT_ZERO;
      else            outcome = OUT_DATA;
   end

   ctf_ptrs #(.AW(AW)) u_ptrs (
      .clk   (clk),
      .rst   (rst),
      .push  (store),
      .pop   (outcome == OUT_DATA),
      .waddr (waddr),
      .raddr (raddr),
      .fill  (fill_level),
      .full  (full),
      .empty (empty)
   );

   ctf_store #(.DW(DW), .AW(AW)) u_store (
      .clk   (clk),
      .we    (store),
      .waddr (waddr),
      .wdata (in_data),
      .raddr (raddr),
      .rdata (rdata)
   );

   ctf_deficit #(.DEFW(DEFW)) u_deficit (
      .clk (clk),
      .rst (rst),
      .inc (outcome == OUT_ZERO),
      .dec (drop),
      .cnt (deficit),
      .nz  (def_nz)
   );

   ctf_satcnt #(.W(ZW), .SAT(TOTAL_SAT)) u_total (
      .clk (clk),
      .rst (rst),
      .inc (outcome == OUT_ZERO),
      .cnt (zero_total)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         running_q <= 1'b0;
         out_q     <= '0;
         zero_q    <= 1'b0;
         flag_q    <= 1'b0;
         nominal_q <= NOM_DEF[AW:0];
      end else begin
         if (start) running_q <= 1'b1;
         case (outcome)
            OUT_DATA: begin
               out_q  <= rdata;
               zero_q <= 1'b0;
            end
            OUT_ZERO: begin
               out_q  <= '0;
               zero_q <= 1'b1;
            end
            default: ;
         endcase
         if (outcome == OUT_ZERO) flag_q <= 1'b1;
         else if (underflow_clr)  flag_q <= 1'b0;
         if (nominal_we) nominal_q <= nominal_in;
      end
   end

   assign out_data       = out_q;
   assign out_zero       = zero_q;
   assign streaming      = running_q;
   assign underflow_flag = flag_q;
   assign level_err      = $signed({1'b0, fill_level}) - $signed({1'b0, nominal_q});
endmodule

// File: rtl/ctf_checker.sv
module ctf_checker #(
   parameter int DW   = 16,
   parameter int AW   = 6,
   parameter int DEFW = 16,
   parameter int ZW   = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            consume_en,
   input logic            in_valid,
   input logic            in_ready,
   input logic [DW-1:0]   out_data,
   input logic            out_zero,
   input logic            streaming,
   input logic [AW:0]     fill_level,
   input logic            nominal_we,
   input logic [AW:0]     nominal_in,
   input logic [AW+1:0]   level_err,
   input logic [DEFW-1:0] deficit,
   input logic            underflow_flag,
   input logic            underflow_clr,
   input logic [ZW-1:0]   zero_total
);
   localparam int DEPTH = 1 << AW;

   logic cons;
   assign cons = streaming && consume_en;

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
      fill_level <= DEPTH[AW:0]);

   p_ready_low_r6: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> (fill_level == DEPTH[AW:0] && deficit == '0));

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !streaming |=> ($stable(out_data) && $stable(zero_total)));

   p_zero_insert_r3: assert property (@(posedge clk) disable iff (rst)
      (cons && fill_level == '0) |=> (out_zero && out_data == '0 && underflow_flag));

   p_drop_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && deficit != '0 && !cons)
      |=> (fill_level == $past(fill_level) && deficit == $past(deficit) - 1'b1));

   p_store_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && deficit == '0 && !cons)
      |=> (fill_level == $past(fill_level) + 1'b1));

   p_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
      (cons && fill_level == '0 && in_valid && deficit == '0)
      |=> (out_zero && fill_level == 1 && deficit == 1));

   p_nominal_r8: assert property (@(posedge clk) disable iff (rst)
      nominal_we |=> ($signed(level_err) ==
                      $signed({2'b00, fill_level}) - $signed({2'b00, $past(nominal_in)})));

   p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (underflow_clr && !(cons && fill_level == '0)) |=> !underflow_flag);

   p_total_sat_r10: assert property (@(posedge clk) disable iff (rst)
      (zero_total == '1) |=> (zero_total == '1));
endmodule

bind coherent_tx_fifo ctf_checker #(.DW(DW), .AW(AW), .DEFW(DEFW), .ZW(ZW)) u_ctf_checker (
   .clk            (clk),
   .rst            (rst),
   .consume_en     (consume_en),
   .in_valid       (in_valid),
   .in_ready       (in_ready),
   .out_data       (out_data),
   .out_zero       (out_zero),
   .streaming      (streaming),
   .fill_level     (fill_level),
   .nominal_we     (nominal_we),
   .nominal_in     (nominal_in),
   .level_err      (level_err),
   .deficit        (deficit),
   .underflow_flag (underflow_flag),
   .underflow_clr  (underflow_clr),
   .zero_total     (zero_total)
);

// File: tb/test_coherent_tx_fifo.sv
module test_coherent_tx_fifo;
   localparam int DW    = 8;
   localparam int AW    = 3;
   localparam int DEFW  = 3;
   localparam int ZW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int DMAX  = (1 << DEFW) - 1;
   localparam int ZMAX  = (1 << ZW) - 1;
   localparam int NOMD  = (DEPTH * 85) / 100;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0, consume_en = 1'b0, in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic nominal_we = 1'b0, underflow_clr = 1'b0;
   logic [AW:0] nominal_in = '0;
   logic in_ready, out_zero, streaming, underflow_flag;
   logic [DW-1:0] out_data;
   logic [AW:0] fill_level;
   logic [AW+1:0] level_err;
   logic [DEFW-1:0] deficit;
   logic [ZW-1:0] zero_total;

   always #4 clk = ~clk;

   coherent_tx_fifo #(.DW(DW), .AW(AW), .DEFW(DEFW), .ZW(ZW)) i_coherent_tx_fifo (
      .clk(clk), .rst(rst), .start(start), .consume_en(consume_en),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_data(out_data), .out_zero(out_zero), .streaming(streaming),
      .fill_level(fill_level), .nominal_we(nominal_we), .nominal_in(nominal_in),
      .level_err(level_err), .deficit(deficit), .underflow_flag(underflow_flag),
      .underflow_clr(underflow_clr), .zero_total(zero_total)
   );

   int errors = 0, checks = 0;
   bit done = 1'b0;

   int q[$];
   int m_def, m_zt, m_out, m_nom;
   bit m_oz, m_flag, m_run;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit m_ready();
      return (m_def != 0) || (q.size() < DEPTH);
   endfunction

   task automatic m_reset();
      q.delete();
      m_def = 0; m_zt = 0; m_out = 0; m_nom = NOMD;
      m_oz = 0; m_flag = 0; m_run = 0;
   endtask

   task automatic m_step(input bit v, input int d, input bit ce, input bit st,
                         input bit clr, input bit nwe, input int nval);
      bit cons, emp, acc;
      int pre_def;
      cons = m_run && ce;
      emp = (q.size() == 0);
      acc = v && m_ready();
      pre_def = m_def;
      if (cons) begin
         if (!emp) begin m_out = q.pop_front(); m_oz = 0; end
         else begin m_out = 0; m_oz = 1; end
      end
      m_def = m_def + ((cons && emp && m_def != DMAX) ? 1 : 0) - ((acc && pre_def != 0) ? 1 : 0);
      if (acc && pre_def == 0) q.push_back(d);
      if (cons && emp) begin
         m_zt = (m_zt == ZMAX) ? ZMAX : m_zt + 1;
         m_flag = 1;
      end else if (clr) m_flag = 0;
      if (st) m_run = 1;
      if (nwe) m_nom = nval;
   endtask

   task automatic compare_all();
      chk(m_oz ? "R3" : "R2", "out_data", out_data, m_out);
      chk("R3", "out_zero", out_zero, m_oz);
      chk("R1", "streaming", streaming, m_run);
      chk("R8", "fill_level", fill_level, q.size());
      chk("R8", "level_err", $signed(level_err), q.size() - m_nom);
      chk("R4", "deficit", deficit, m_def);
      chk("R10", "zero_total", zero_total, m_zt);
      chk("R9", "underflow_flag", underflow_flag, m_flag);
      chk("R6", "in_ready", in_ready, m_ready());
   endtask

   task automatic cyc(input bit v, input int d, input bit ce, input bit st,
                      input bit clr, input bit nwe, input int nval);
      @(negedge clk);
      in_valid = v; in_data = d[DW-1:0]; consume_en = ce; start = st;
      underflow_clr = clr; nominal_we = nwe; nominal_in = nval[AW:0];
      m_step(v, d, ce, st, clr, nwe, nval);
      @(posedge clk);
      #2;
      compare_all();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 0; consume_en = 0; start = 0;
      underflow_clr = 0; nominal_we = 0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      m_reset();
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7341));
      do_reset();
      // R12: reset state
      chk("R12", "fill after reset", fill_level, 0);
      chk("R12", "ready after reset", in_ready, 1);
      chk("R12", "deficit after reset", deficit, 0);
      chk("R12", "streaming after reset", streaming, 0);
      chk("R12", "out_zero after reset", out_zero, 0);
      chk("R12", "total after reset", zero_total, 0);
      chk("R8", "default level_err", $signed(level_err), -NOMD);

      // R1: preload while consume_en is high but not started
      cyc(1, 11, 1, 0, 0, 0, 0);
      cyc(1, 22, 1, 0, 0, 0, 0);
      cyc(1, 33, 1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R1", "out_data before start", out_data, 0);
      chk("R1", "fill before start", fill_level, 3);
      chk("R1", "zeros before start", zero_total, 0);
      cyc(0, 0, 0, 1, 0, 0, 0);
      chk("R1", "streaming after start", streaming, 1);

      // R2: in-order drain
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R2", "first sample", out_data, 11);
      cyc(0, 0, 1, 0, 0, 0, 0);
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R2", "third sample", out_data, 33);

      // R3 / R11: nine zero insertions, deficit saturates at 7
      for (int i = 0; i < 9; i++) cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R11", "deficit at limit", deficit, DMAX);
      chk("R10", "zero count", zero_total, 9);
      chk("R9", "flag set", underflow_flag, 1);

      // R4: late samples dropped
      for (int i = 0; i < DMAX; i++) cyc(1, 100 + i, 0, 0, 0, 0, 0);
      chk("R4", "fill after drops", fill_level, 0);
      chk("R4", "deficit after drops", deficit, 0);

      // R5: first sample after deficit cleared is stored
      cyc(1, 8'hA5, 0, 0, 0, 0, 0);
      chk("R5", "fill after resume", fill_level, 1);
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R5", "resumed sample", out_data, 8'hA5);

      // R7: simultaneous write and consume on empty buffer
      cyc(1, 8'h5A, 1, 0, 0, 0, 0);
      chk("R7", "zero output", out_zero, 1);
      chk("R7", "stored", fill_level, 1);
      chk("R7", "deficit", deficit, 1);
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk("R7", "stored sample out", out_data, 8'h5A);

      // R9: clear the sticky flag
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk("R9", "flag cleared", underflow_flag, 0);

      // R6: fill to full (first write drops the deficit of 1)
      for (int i = 0; i < DEPTH + 1; i++) cyc(1, 40 + i, 0, 0, 0, 0, 0);
      chk("R6", "full fill", fill_level, DEPTH);
      chk("R6", "ready low when full", in_ready, 0);
      cyc(1, 99, 0, 0, 0, 0, 0);
      chk("R6", "write ignored when full", fill_level, DEPTH);

      // R8: nominal load
      cyc(0, 0, 0, 0, 0, 1, 3);
      chk("R8", "level_err after load", $signed(level_err), DEPTH - 3);

      // random phase
      for (int ph = 0; ph < 4; ph++) begin
         for (int i = 0; i < 1500; i++) begin
            int pv, pc;
            pv = (ph == 0) ? 70 : (ph == 1) ? 30 : (ph == 2) ? 50 : 90;
            pc = (ph == 0) ? 50 : (ph == 1) ? 80 : (ph == 2) ? 50 : 40;
            cyc(($urandom % 100) < pv, $urandom % 256, ($urandom % 100) < pc, 0,
                ($urandom % 50) == 0, ($urandom % 100) == 0, $urandom % (DEPTH + 1));
         end
      end
      chk("R10", "total saturated", zero_total, ZMAX);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule